// File: doc/BRIEF.md
# Dispatcher Request and Interrupt-Exit Controller

This block sits in the control path of a stack-based processor and decides what happens when software asks for the dispatcher or leaves an interrupt routine. It holds a nesting counter that software raises and lowers around critical sections. While that counter is non-zero, dispatching is off. It also holds a flag that records a dispatch request made while dispatching was off, so the request is deferred and not lost.

Four one-cycle command strobes drive the block: disable dispatch, enable dispatch, request dispatch and interrupt exit. For an interrupt exit, the caller supplies:
- the sign bit and marker value of the current frame;
- the sign bit and marker value of the interrupt-stack base;
- the code-segment number of the routine being left;
- a device number.

One cycle later the block reports a 3-bit return-target code. When the routine was an external one, it also pulses a reset-interrupt toward the device. A request made while dispatching is off gives a fetch-next pulse. An enable command issued with the counter already at zero sets a sticky halt flag.

Top module: `dispatch_exit_ctrl`

## Requirements
- R1: After reset, the outputs are as follows. `tgt_vld_o`, `tgt_code_o`, `dev_rst_o`, `dev_num_o`, `fetch_o` and `halt_o` are all 0. The nesting count and the pending flag are 0.
- R2: The nesting count changes as follows. A disable strobe adds one, saturating at 2^CNT_W-1. An enable strobe subtracts one only when the count is non-zero. With CNT_W=4, twenty disables followed by fifteen enables leave the count at zero without raising halt.
- R3: A request strobe while the count is non-zero sets the pending flag. One cycle later `fetch_o` pulses high, and no target is reported.
- R4: A request strobe while the count is zero reports target code 4 (dispatcher launch) on the next cycle.
- R5: An enable strobe while the count is zero sets `halt_o` on the next cycle. `halt_o` then stays high until reset, and the count stays zero.
- R6: An enable strobe that takes the count from 1 to 0 clears the pending flag. If the flag was set, target code 4 is reported on the next cycle. Otherwise no target is reported.
- R7: On an exit strobe with segment number different from SYS_SEG (default 1), `dev_rst_o` pulses on the next cycle with `dev_num_o` equal to the device number. Otherwise `dev_rst_o` stays low. `dev_num_o` is 0 whenever `dev_rst_o` is low.
- R8: Exit with frame sign 0 gives one of two codes. If the frame and base markers are equal, the code is 1 (interrupted process). If they differ, the code is 2 (lower-priority interrupt).
- R9: Exit with frame sign 1 and base sign 0 reports code 3 (interrupted dispatcher).
- R10: Exit with both signs 1 and the count zero reports code 4, whatever the markers are, and clears the pending flag.
- R11: Exit with both signs 1 and the count non-zero gives one of two codes. If the markers are equal, the code is 1. If they differ, the code is 3. The pending flag is unchanged.
- R12: `tgt_vld_o` is high for exactly one cycle, only after an exit, request or enable strobe, and never together with `fetch_o`. If several strobes arrive in one cycle, only one is accepted, in the priority order exit, request, enable, disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_disable_i | input | 1 | Disable-dispatch strobe |
| cmd_enable_i | input | 1 | Enable-dispatch strobe |
| cmd_request_i | input | 1 | Request-dispatch strobe |
| cmd_exit_i | input | 1 | Interrupt-exit strobe |
| frame_sign_i | input | 1 | Bit 0 of the current frame marker |
| frame_mark_i | input | MARK_W | Current frame marker value |
| base_sign_i | input | 1 | Bit 0 of the interrupt-stack base marker |
| base_mark_i | input | MARK_W | Interrupt-stack base marker value |
| seg_i | input | SEG_W | Code-segment number of the exiting routine |
| dev_i | input | DEV_W | Device number for the reset-interrupt |
| tgt_vld_o | output | 1 | Return-target code valid |
| tgt_code_o | output | 3 | Return target: 1 process, 2 lower interrupt, 3 dispatcher, 4 launch |
| dev_rst_o | output | 1 | Reset-interrupt pulse to a device |
| dev_num_o | output | DEV_W | Device addressed by the pulse |
| fetch_o | output | 1 | Dispatch deferred, fetch next instruction |
| halt_o | output | 1 | Sticky system halt |

## Verification
The nesting count and pending flag cannot be seen directly. A wrong value shows up in three ways:
- a target code of 1 or 3 where 4 was due, or the reverse;
- a missing or extra launch when the count returns to zero;
- a halt that comes one enable too early or too late.

A saturation or decrement error stays hidden until the matching enable run, which may be many commands later. An exit decode error shows on the very next cycle. The bench follows the count and flag in its own model and compares every output after each command.

// File: rtl/dx_pkg.sv
package dx_pkg;
   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_PROC   = 3'd1,
      TGT_LOWER  = 3'd2,
      TGT_DRET   = 3'd3,
      TGT_LAUNCH = 3'd4
   } dx_tgt_e;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_DIS  = 3'd1,
      OP_ENA  = 3'd2,
      OP_REQ  = 3'd3,
      OP_EXIT = 3'd4
   } dx_op_e;
endpackage

// File: rtl/dx_strobe_sel.sv
module dx_strobe_sel
   import dx_pkg::*;
(
   input  logic   dis_i,
   input  logic   ena_i,
   input  logic   req_i,
   input  logic   ext_i,
   output dx_op_e op_o
);
   // one command per cycle: exit, then request, then enable, then disable
   always_comb begin
      if (ext_i)      op_o = OP_EXIT;
      else if (req_i) op_o = OP_REQ;
      else if (ena_i) op_o = OP_ENA;
      else if (dis_i) op_o = OP_DIS;
      else            op_o = OP_NONE;
   end
endmodule

// File: rtl/dx_nest_cnt.sv
module dx_nest_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             dec_i,
   input  logic             set_pend_i,
   input  logic             clr_pend_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pend_o
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         if (cnt_q != CMAX) cnt_q <= cnt_q + ONE;
      end else if (dec_i) begin
         if (cnt_q != '0) cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (clr_pend_i) pend_q <= 1'b0;
      else if (set_pend_i) pend_q <= 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/dx_exit_decode.sv
module dx_exit_decode
   import dx_pkg::*;
#(
   parameter int MARK_W = 16,
   parameter int CMP_W  = 16
) (
   input  logic              frame_sign_i,
   input  logic [MARK_W-1:0] frame_mark_i,
   input  logic              base_sign_i,
   input  logic [MARK_W-1:0] base_mark_i,
   input  logic              cnt_nz_i,
   output dx_tgt_e           tgt_o,
   output logic              clr_pend_o
);
   logic same;

   generate
      if (CMP_W == MARK_W) begin : g_full_cmp
         assign same = (frame_mark_i == base_mark_i);
      end else begin : g_part_cmp
         assign same = (frame_mark_i[CMP_W-1:0] == base_mark_i[CMP_W-1:0]);
      end
   endgenerate

   always_comb begin
      clr_pend_o = 1'b0;
      if (!frame_sign_i) begin
         tgt_o = same ? TGT_PROC : TGT_LOWER;
      end else if (!base_sign_i) begin
         tgt_o = TGT_DRET;
      end else if (!cnt_nz_i) begin
         tgt_o      = TGT_LAUNCH;
         clr_pend_o = 1'b1;
      end else begin
         tgt_o = same ? TGT_PROC : TGT_DRET;
      end
   end
endmodule

// File: rtl/dispatch_exit_ctrl.sv
module dispatch_exit_ctrl
   import dx_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int MARK_W  = 16,
   parameter int CMP_W   = 16,
   parameter int SEG_W   = 8,
   parameter int DEV_W   = 8,
   parameter int SYS_SEG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_disable_i,
   input  logic              cmd_enable_i,
   input  logic              cmd_request_i,
   input  logic              cmd_exit_i,
   input  logic              frame_sign_i,
   input  logic [MARK_W-1:0] frame_mark_i,
   input  logic              base_sign_i,
   input  logic [MARK_W-1:0] base_mark_i,
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [DEV_W-1:0]  dev_i,
   output logic              tgt_vld_o,
   output logic [2:0]        tgt_code_o,
   output logic              dev_rst_o,
   output logic [DEV_W-1:0]  dev_num_o,
   output logic              fetch_o,
   output logic              halt_o
);
   localparam logic [SEG_W-1:0] SYS_SEG_V = SEG_W'(SYS_SEG);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("dispatch_exit_ctrl: CNT_W must be 1..16");
      end
      if (CMP_W < 1 || CMP_W > MARK_W) begin : g_bad_cmp
         $error("dispatch_exit_ctrl: CMP_W must be 1..MARK_W");
      end
      if (SYS_SEG < 0 || SYS_SEG >= (1 << SEG_W)) begin : g_bad_seg
         $error("dispatch_exit_ctrl: SYS_SEG does not fit SEG_W");
      end
   endgenerate

   dx_op_e           op;
   logic [CNT_W-1:0] cnt_w;
   logic             pend_w;
   logic             nz, last;
   dx_tgt_e          exit_tgt;
   logic             exit_clr;
   logic             inc, dec, set_pend, clr_pend;

   dx_strobe_sel u_sel (
      .dis_i (cmd_disable_i),
      .ena_i (cmd_enable_i),
      .req_i (cmd_request_i),
      .ext_i (cmd_exit_i),
      .op_o  (op)
   );

   assign nz   = (cnt_w != '0);
   assign last = (cnt_w == CNT_ONE);

   dx_exit_decode #(.MARK_W(MARK_W), .CMP_W(CMP_W)) u_dec (
      .frame_sign_i (frame_sign_i),
      .frame_mark_i (frame_mark_i),
      .base_sign_i  (base_sign_i),
      .base_mark_i  (base_mark_i),
      .cnt_nz_i     (nz),
      .tgt_o        (exit_tgt),
      .clr_pend_o   (exit_clr)
   );

   assign inc      = (op == OP_DIS);
   assign dec      = (op == OP_ENA) && nz;
   assign set_pend = (op == OP_REQ) && nz;
   assign clr_pend = ((op == OP_EXIT) && exit_clr) || ((op == OP_ENA) && last);

   dx_nest_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (inc),
      .dec_i      (dec),
      .set_pend_i (set_pend),
      .clr_pend_i (clr_pend),
      .cnt_o      (cnt_w),
      .pend_o     (pend_w)
   );

   logic             vld_d;
   dx_tgt_e          code_d;
   logic             rst_d;

   always_comb begin
      vld_d  = 1'b0;
      code_d = TGT_NONE;
      unique case (op)
         OP_EXIT: begin
            vld_d  = 1'b1;
            code_d = exit_tgt;
         end
         OP_REQ: if (!nz) begin
            vld_d  = 1'b1;
            code_d = TGT_LAUNCH;
         end
         OP_ENA: if (last && pend_w) begin
            vld_d  = 1'b1;
            code_d = TGT_LAUNCH;
         end
         default: ;
      endcase
   end

   assign rst_d = (op == OP_EXIT) && (seg_i != SYS_SEG_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_vld_o  <= 1'b0;
         tgt_code_o <= 3'd0;
         dev_rst_o  <= 1'b0;
         dev_num_o  <= '0;
         fetch_o    <= 1'b0;
         halt_o     <= 1'b0;
      end else begin
         tgt_vld_o  <= vld_d;
         tgt_code_o <= code_d;
         dev_rst_o  <= rst_d;
         dev_num_o  <= rst_d ? dev_i : '0;
         fetch_o    <= set_pend;
         halt_o     <= halt_o | ((op == OP_ENA) && !nz);
      end
   end
endmodule

// File: rtl/dx_exit_chk.sv
module dx_exit_chk #(
   parameter int CNT_W   = 4,
   parameter int SEG_W   = 8,
   parameter int SYS_SEG = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_disable_i,
   input logic             cmd_enable_i,
   input logic             cmd_request_i,
   input logic             cmd_exit_i,
   input logic [SEG_W-1:0] seg_i,
   input logic             tgt_vld_o,
   input logic             dev_rst_o,
   input logic             fetch_o,
   input logic             halt_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic             pend_q
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o);

   assert_pend_needs_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q != '0));

   assert_fetch_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |-> ($past(cmd_request_i) && !$past(cmd_exit_i) && ($past(cnt_q) != '0)));

   assert_vld_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_vld_o |-> $past(cmd_exit_i || cmd_request_i || cmd_enable_i));

   assert_vld_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tgt_vld_o, fetch_o}));

   assert_devrst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst_o |-> ($past(cmd_exit_i) && ($past(seg_i) != SEG_W'(SYS_SEG))));

   assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CMAX && cmd_disable_i && !cmd_enable_i && !cmd_request_i && !cmd_exit_i)
      |=> (cnt_q == CMAX));
endmodule

bind dispatch_exit_ctrl dx_exit_chk #(
   .CNT_W(CNT_W), .SEG_W(SEG_W), .SYS_SEG(SYS_SEG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_disable_i (cmd_disable_i),
   .cmd_enable_i  (cmd_enable_i),
   .cmd_request_i (cmd_request_i),
   .cmd_exit_i    (cmd_exit_i),
   .seg_i         (seg_i),
   .tgt_vld_o     (tgt_vld_o),
   .dev_rst_o     (dev_rst_o),
   .fetch_o       (fetch_o),
   .halt_o        (halt_o),
   .cnt_q         (cnt_w),
   .pend_q        (pend_w)
);

// File: tb/tb_dispatch_exit_ctrl.sv
`timescale 1ns/1ps
module tb_dispatch_exit_ctrl;
   localparam int CMAX = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dis = 0, ena = 0, req = 0, ext = 0;
   logic        fs = 0, bs = 0;
   logic [15:0] fm = 0, bm = 0;
   logic [7:0]  seg = 0, dev = 0;
   logic        vld, drst, fetch, halt;
   logic [2:0]  code;
   logic [7:0]  dnum;

   int total = 0, bad = 0;
   int m_cnt = 0;
   bit m_pend = 0, m_halt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dispatch_exit_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_disable_i(dis), .cmd_enable_i(ena), .cmd_request_i(req), .cmd_exit_i(ext),
      .frame_sign_i(fs), .frame_mark_i(fm), .base_sign_i(bs), .base_mark_i(bm),
      .seg_i(seg), .dev_i(dev),
      .tgt_vld_o(vld), .tgt_code_o(code), .dev_rst_o(drst), .dev_num_o(dnum),
      .fetch_o(fetch), .halt_o(halt)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // exit target from the requirements (R8..R11)
   function automatic int exit_code(bit f, bit b, bit eq, int cnt, output string tag);
      if (!f) begin tag = "R8"; return eq ? 1 : 2; end
      if (!b) begin tag = "R9"; return 3; end
      if (cnt == 0) begin tag = "R10"; return 4; end
      tag = "R11"; return eq ? 1 : 3;
   endfunction

   task automatic step(input bit d, input bit e, input bit r, input bit x);
      bit   e_vld, e_fetch, e_rst;
      int   e_code, e_dev;
      string tag;
      dis = d; ena = e; req = r; ext = x;
      @(posedge clk);
      e_vld = 0; e_code = 0; e_fetch = 0; e_rst = 0; e_dev = 0; tag = "R12";
      if (x) begin
         e_vld = 1;
         e_code = exit_code(fs, bs, fm == bm, m_cnt, tag);
         if (e_code == 4) m_pend = 0;
         if (seg != 8'd1) begin e_rst = 1; e_dev = dev; end
      end else if (r) begin
         if (m_cnt != 0) begin m_pend = 1; e_fetch = 1; tag = "R3"; end
         else begin e_vld = 1; e_code = 4; tag = "R4"; end
      end else if (e) begin
         if (m_cnt == 0) begin m_halt = 1; tag = "R5"; end
         else begin
            if (m_cnt == 1) begin
               if (m_pend) begin e_vld = 1; e_code = 4; end
               m_pend = 0; tag = "R6";
            end else tag = "R2";
            m_cnt--;
         end
      end else if (d) begin
         if (m_cnt < CMAX) m_cnt++;
         tag = "R2";
      end
      @(negedge clk);
      chk(tag, "tgt_vld", vld, e_vld);
      chk(tag, "tgt_code", code, e_code);
      chk(tag, "fetch", fetch, e_fetch);
      chk((x ? "R7" : tag), "dev_rst", drst, e_rst);
      chk("R7", "dev_num", dnum, e_dev);
      chk((tag == "R5") ? "R5" : tag, "halt", halt, m_halt);
      dis = 0; ena = 0; req = 0; ext = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_cnt = 0; m_pend = 0; m_halt = 0;
      chk("R1", "tgt_vld", vld, 0);
      chk("R1", "tgt_code", code, 0);
      chk("R1", "dev_rst", drst, 0);
      chk("R1", "dev_num", dnum, 0);
      chk("R1", "fetch", fetch, 0);
      chk("R1", "halt", halt, 0);
   endtask

   task automatic set_exit(input bit f, input bit b, input bit eq, input int s);
      fs = f; bs = b;
      bm = 16'($urandom);
      fm = eq ? bm : bm ^ 16'h0104;
      seg = 8'(s); dev = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      @(negedge clk);
      do_reset();

      // directed exit corners, count zero (R8, R9, R10, R7)
      set_exit(0, 0, 1, 1); step(0, 0, 0, 1);   // R8 process, system segment: no reset pulse
      set_exit(0, 1, 0, 3); step(0, 0, 0, 1);   // R8 lower-priority, external: pulse
      set_exit(1, 0, 1, 2); step(0, 0, 0, 1);   // R9
      set_exit(1, 1, 0, 1); step(0, 0, 0, 1);   // R10 unequal
      set_exit(1, 1, 1, 1); step(0, 0, 0, 1);   // R10 equal
      step(0, 0, 1, 0);                         // R4 immediate launch
      // deferred dispatch (R3, R11, R6)
      step(1, 0, 0, 0); step(1, 0, 0, 0);
      step(0, 0, 1, 0);                         // R3 fetch pulse, pending
      set_exit(1, 1, 1, 5); step(0, 0, 0, 1);   // R11 equal -> process
      set_exit(1, 1, 0, 1); step(0, 0, 0, 1);   // R11 unequal -> dispatcher
      step(0, 1, 0, 0);                         // R2 count 2 -> 1
      step(0, 1, 0, 0);                         // R6 launch of deferred request
      step(1, 0, 0, 0); step(0, 1, 0, 0);       // R6 no pending: no target
      // collision: exit wins over request (R12)
      step(1, 0, 0, 0);
      set_exit(0, 0, 1, 1); step(0, 0, 1, 1);
      step(0, 1, 0, 0);                         // pending untouched -> no launch
      // saturation (R2)
      for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
      for (int i = 0; i < CMAX; i++) step(0, 1, 0, 0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         int pick = int'($urandom % 10);
         set_exit(1'($urandom), 1'($urandom), ($urandom % 2) == 0, int'($urandom % 3));
         if (pick < 3)      step(1, 0, 0, 0);
         else if (pick < 5) step(0, m_cnt > 0, 0, 0);
         else if (pick < 7) step(0, 0, 1, 0);
         else               step(0, 0, 0, 1);
      end

      // halt (R5) then reset clears it (R1)
      while (m_cnt > 0) step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      step(0, 0, 0, 0);
      chk("R5", "halt sticky", halt, 1);
      do_reset();
      finished = 1;
   end

   initial begin
      fork
         begin wait (finished); end
         begin
            repeat (100000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule